// File: doc/BRIEF.md
# Edge-Timing Bit Error Rate Alarm

This block estimates the line bit error rate from the timing of data transitions, and drives an alarm when that estimate goes above a programmed limit. A phase sampler upstream of the block gives one strobe per received bit. With each strobe it also gives a flag that is set when a transition in that bit fell outside its expected timing window. Each flagged bit counts as one bit error.

The limit is chosen on a logarithmic scale by a small exponent code. Each nonzero code selects an observation window measured in bits, and the window is ten times shorter for each step of the code. When a window ends, the alarm is asserted (driven low) if the window held at least a set number of errors. Otherwise it is released. The alarm has no hysteresis, so one clean window is enough to clear it. Code zero, or a low enable, turns the function off.

Top module: `ber_edge_alarm`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `alarm_n` is 1. Both counters are cleared.
- R2: `edge_late` counts as an error only in a cycle where `bit_stb` is 1. In any other cycle it has no effect.
- R3: The active codes are 1 to 5. Code c gives a window of MIN_WIN·RATIO^(5−c) strobes, so code 1 is the longest window (1e-10 by default) and code 5 is the shortest (1e-6). Codes 6 and 7 act as code 5.
- R4: On the strobe that completes a window, the error total of that window, including the completing bit, is evaluated. From the next cycle, `alarm_n` is 0 if the total is at least TRIP and 1 if it is not. No hysteresis applies.
- R5: While the block is active, `alarm_n` changes only in the cycle after a window completes.
- R6: The strobe count and the error count both clear when a window completes, and the next strobe starts a new window.
- R7: The error count saturates at 2^ERR_W−1 and does not wrap.
- R8: With `thr_code` = 0, `alarm_n` is 1 from the next cycle on, and both counters stay clear.
- R9: With `en` = 0, `alarm_n` is 1 from the next cycle on, and both counters stay clear.
- R10: A cycle in which an active `thr_code` differs from the previous cycle's value discards the current window, including any strobe in that cycle. `alarm_n` holds its value and the next strobe starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Function enable |
| thr_code | input | 3 | Exponent code of the rate limit; 0 turns the alarm off |
| bit_stb | input | 1 | One pulse per received bit |
| edge_late | input | 1 | Transition of this bit fell outside its timing window |
| alarm_n | output | 1 | Rate alarm, active low, registered |

## Verification
The first window patterns use the shortest window. They are: a clean window, an error on the first bit, an error on only the completing bit, and late flags given between strobes. Together these separate correct counting from off-by-one evaluation and from counting without a strobe. Long-window runs check the alarm partway through a window and again at its end, which tells the correct length for each code apart from a shorter one. A burst of exactly 2^ERR_W errors shows whether the counter saturates or wraps back to zero. Switching codes in the middle of an errored window, and turning the block off with errors present, show that stale errors are discarded.

// File: rtl/ber_pkg.sv
package ber_pkg;

  localparam int NUM_LVL = 5;
  localparam int CODE_W  = 3;

  typedef logic [CODE_W-1:0] thr_code_t;

  // Window length for table slot g: base * ratio^g (slot 0 = shortest window).
  function automatic logic [63:0] win_len(input logic [63:0] base,
                                          input logic [63:0] ratio,
                                          input int          g);
    logic [63:0] acc;
    acc = base;
    for (int i = 0; i < g; i++) acc = acc * ratio;
    return acc;
  endfunction

endpackage

// File: rtl/ber_win_len.sv
module ber_win_len
  import ber_pkg::*;
#(
  parameter logic [63:0] MIN_WIN = 64'd1000000,
  parameter logic [63:0] RATIO   = 64'd10,
  parameter int          WIN_W   = 34
) (
  input  thr_code_t        code,
  output logic [WIN_W-1:0] last_idx
);

  logic [WIN_W-1:0] tab [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign tab[g] = WIN_W'(win_len(MIN_WIN, RATIO, g) - 64'd1);
  end

  always_comb begin
    int slot;
    if (code == '0)                  slot = NUM_LVL - 1;
    else if (int'(code) >= NUM_LVL)  slot = 0;
    else                             slot = NUM_LVL - int'(code);
    last_idx = tab[slot];
  end

endmodule

// File: rtl/ber_win_cnt.sv
module ber_win_cnt #(
  parameter int WIN_W = 34
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             stb,
  input  logic [WIN_W-1:0] last_idx,
  output logic             at_last
);

  logic [WIN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (stb)    cnt <= cnt + 1'b1;
  end

  assign at_last = (cnt == last_idx);

endmodule

// File: rtl/ber_err_cnt.sv
module ber_err_cnt #(
  parameter int ERR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [ERR_W-1:0] cnt,
  output logic [ERR_W-1:0] total
);

  localparam logic [ERR_W-1:0] CMAX = '1;

  logic bump;
  assign bump  = inc && (cnt != CMAX);
  assign total = bump ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (bump)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/ber_edge_alarm.sv
module ber_edge_alarm
  import ber_pkg::*;
#(
  parameter logic [63:0] MIN_WIN = 64'd1000000,
  parameter logic [63:0] RATIO   = 64'd10,
  parameter int          ERR_W   = 8,
  parameter int          TRIP    = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [2:0] thr_code,
  input  logic       bit_stb,
  input  logic       edge_late,
  output logic       alarm_n
);

  localparam logic [63:0] MAX_WIN = MIN_WIN * RATIO * RATIO * RATIO * RATIO;
  localparam int          WIN_W   = $clog2(MAX_WIN + 64'd1);

  thr_code_t        code_q;
  logic             active, restart, win_end, clr, inc, at_last;
  logic [WIN_W-1:0] last_idx;
  logic [ERR_W-1:0] err_cnt, err_total;

  assign active  = en && (thr_code != '0);
  assign restart = active && (thr_code != code_q);
  assign win_end = active && !restart && bit_stb && at_last;
  assign clr     = !active || restart || win_end;
  assign inc     = active && !restart && bit_stb && edge_late;

  always_ff @(posedge clk) begin
    if (rst) code_q <= '0;
    else     code_q <= thr_code;
  end

  ber_win_len #(.MIN_WIN(MIN_WIN), .RATIO(RATIO), .WIN_W(WIN_W)) u_len (
    .code     (thr_code),
    .last_idx (last_idx)
  );

  ber_win_cnt #(.WIN_W(WIN_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .stb      (bit_stb && active && !restart),
    .last_idx (last_idx),
    .at_last  (at_last)
  );

  ber_err_cnt #(.ERR_W(ERR_W)) u_err (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr),
    .inc   (inc),
    .cnt   (err_cnt),
    .total (err_total)
  );

  always_ff @(posedge clk) begin
    if (rst || !active) alarm_n <= 1'b1;
    else if (win_end)   alarm_n <= !(err_total >= ERR_W'(TRIP));
  end

endmodule

// File: rtl/ber_edge_alarm_chk.sv
module ber_edge_alarm_chk #(
  parameter int ERR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [2:0]       thr_code,
  input logic             bit_stb,
  input logic             edge_late,
  input logic             alarm_n,
  input logic             win_end,
  input logic             active,
  input logic [ERR_W-1:0] err_cnt
);

  localparam logic [ERR_W-1:0] CMAX = '1;

  AST_OFF_BY_CODE: assert property (@(posedge clk) disable iff (rst)
    (thr_code == 3'd0) |=> (alarm_n && err_cnt == '0)); // R8

  AST_OFF_BY_EN: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> (alarm_n && err_cnt == '0)); // R9

  AST_HOLD_MID_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (active && !win_end) |=> $stable(alarm_n)); // R5

  AST_TRIP_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(alarm_n) |-> $past(err_cnt != '0 || (bit_stb && edge_late))); // R4

  AST_ERR_SAT: assert property (@(posedge clk) disable iff (rst)
    (active && !win_end && err_cnt == CMAX && thr_code == $past(thr_code))
      |=> (err_cnt == CMAX || !active)); // R7

  AST_CODE_RESTART: assert property (@(posedge clk) disable iff (rst)
    (active && thr_code != $past(thr_code)) |=> (err_cnt == '0)); // R10

endmodule

bind ber_edge_alarm ber_edge_alarm_chk #(.ERR_W(ERR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .thr_code  (thr_code),
  .bit_stb   (bit_stb),
  .edge_late (edge_late),
  .alarm_n   (alarm_n),
  .win_end   (win_end),
  .active    (active),
  .err_cnt   (err_cnt)
);

// File: tb/ber_edge_alarm_tb.sv
module ber_edge_alarm_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [2:0] thr_code = 3'd0;
  logic       bit_stb = 1'b0;
  logic       edge_late = 1'b0;
  logic       alarm_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic  val;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // windows: code5=4, code4=8, code3=16, code2=32, code1=64; error count 3 bits
  ber_edge_alarm #(.MIN_WIN(64'd4), .RATIO(64'd2), .ERR_W(3), .TRIP(1)) u_dut (
    .clk(clk), .rst(rst), .en(en), .thr_code(thr_code),
    .bit_stb(bit_stb), .edge_late(edge_late), .alarm_n(alarm_n)
  );

  task automatic check(input logic exp, input string tag);
    checks++;
    if (alarm_n !== exp) begin
      failures++;
      $display("FAIL %s alarm_n act=%0b exp=%0b", tag, alarm_n, exp);
    end
  endtask

  task automatic expect_now(input logic v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.val, e.tag);
    end
  end

  task automatic one_bit(input logic late);
    @(negedge clk);
    bit_stb = 1'b1;
    edge_late = late;
    @(posedge clk);
    #1;
    bit_stb = 1'b0;
    edge_late = 1'b0;
  endtask

  task automatic gap(input logic late);
    @(negedge clk);
    bit_stb = 1'b0;
    edge_late = late;
    @(posedge clk);
    #1;
    edge_late = 1'b0;
  endtask

  // n bits; errors on bits [e0, e0+ne); optional expectation after the last bit
  task automatic drive(input int n, input int e0, input int ne,
                       input bit push, input logic v, input string tag);
    for (int i = 0; i < n; i++) one_bit(i >= e0 && i < e0 + ne);
    if (push) expect_now(v, tag);
  endtask

  task automatic set_code(input logic [2:0] c);
    @(negedge clk);
    thr_code = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(1'b1, "R1 in reset");
    @(negedge clk);
    rst = 1'b0;
    en = 1'b1;
    @(negedge clk);
    check(1'b1, "R1 after reset");
    set_code(3'd5);
    gap(1'b0);

    // shortest window (4)
    drive(4, 0, 0, 1, 1'b1, "R4 clean window");
    drive(4, 0, 1, 1, 1'b0, "R4 first-bit error");
    drive(4, 0, 0, 1, 1'b1, "R4 release no hysteresis");
    drive(4, 3, 1, 1, 1'b0, "R4 error on completing bit");
    drive(3, 0, 0, 1, 1'b0, "R5 hold mid window");
    drive(1, 0, 0, 1, 1'b1, "R6 fresh window after boundary");

    // late flags between strobes are ignored
    for (int i = 0; i < 4; i++) begin
      gap(1'b1);
      one_bit(1'b0);
    end
    expect_now(1'b1, "R2 late without strobe");

    // code 3: window 16
    set_code(3'd3);
    drive(16, 0, 1, 1, 1'b0, "R3 code3 errored window");
    drive(15, 0, 0, 1, 1'b0, "R3 code3 no boundary before 16");
    drive(1, 0, 0, 1, 1'b1, "R3 code3 boundary at 16");

    // code 1: window 64
    set_code(3'd1);
    drive(64, 10, 1, 1, 1'b0, "R3 code1 errored window");
    drive(63, 0, 0, 1, 1'b0, "R3 code1 no boundary before 64");
    drive(1, 0, 0, 1, 1'b1, "R3 code1 boundary at 64");

    // code 7 behaves as code 5
    set_code(3'd7);
    drive(4, 1, 1, 1, 1'b0, "R3 code7 window of 4");
    drive(4, 0, 0, 1, 1'b1, "R3 code7 clean");

    // saturation: exactly 8 errors into a 3-bit counter
    set_code(3'd3);
    drive(16, 0, 8, 1, 1'b0, "R7 saturate not wrap");

    // code switch mid-window discards errors
    set_code(3'd5);
    drive(4, 0, 0, 1, 1'b1, "R10 clean before switch");
    drive(2, 0, 1, 0, 1'b0, "");
    set_code(3'd4);
    drive(4, 0, 0, 1, 1'b1, "R10 old window discarded");
    drive(4, 0, 0, 1, 1'b1, "R10 new window clean");

    // disable by code 0
    set_code(3'd5);
    drive(4, 0, 1, 1, 1'b0, "R8 armed");
    set_code(3'd0);
    expect_now(1'b1, "R8 code zero releases");
    drive(8, 0, 8, 1, 1'b1, "R8 errors ignored");

    // disable by enable
    set_code(3'd5);
    drive(4, 0, 1, 1, 1'b0, "R9 armed");
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    #1;
    expect_now(1'b1, "R9 enable low releases");
    drive(8, 0, 8, 1, 1'b1, "R9 errors ignored");
    @(negedge clk);
    en = 1'b1;
    gap(1'b0);
    drive(4, 0, 0, 1, 1'b1, "R9 clean after re-enable");

    repeat (3) @(posedge clk);
    wait (exp_q.size() == 0);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule